// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Requests

This block sits between a register-style host port and a serial audio shifter. It holds two sample queues of 32 entries each. The host fills the transmit queue and the shifter drains it. The shifter fills the receive queue and the host drains it. The host sees the live fill level of each queue in a status word. Each direction raises a request once its fill level passes a programmable level: the transmit side when it is running low, the receive side when it holds more than its level.

Each request is backed by a sticky flag that the host clears by writing zero to it. A per-direction enable gates the flag onto the request pin. Either queue can be held empty by its own reset bit while the other direction keeps running. A self-clearing soft-reset bit empties both queues and drops both flags in one step, and leaves the programmed levels and enables as they were.

The host map uses word addresses 0 (control), 1 (status), 2 (transmit data, write), 3 (receive data, read) and 4 (levels). Reads are combinational from the address. A read at address 3 with `hostRd` high removes one entry.

Top module: `audio_fifo_req`

## Requirements
- R1: Each queue holds up to 32 samples and returns them in the order they were written.
- R2: The status word at address 1 carries the transmit fill count in bits 29:24 and the receive fill count in bits 13:8. Both counts are updated at the clock edge that accepts a push or pop.
- R3: A host write to a full transmit queue and a shifter push into a full receive queue are dropped. A host read at address 3 from an empty receive queue returns zero and changes nothing.
- R4: The transmit-low flag (status bit 16) is set at the edge after any cycle in which the transmit count is less than or equal to the transmit level (address 4 bits 12:8). Once set, it stays set.
- R5: The receive-high flag (status bit 0) is set at the edge after any cycle in which the receive count is greater than the receive level (address 4 bits 4:0). Once set, it stays set.
- R6: Writing status with a flag bit at 0 clears that flag, unless its set condition still holds in that cycle. Writing the bit as 1 leaves the flag unchanged.
- R7: `txReq` is the transmit-low flag gated by control bit 3. `rxReq` is the receive-high flag gated by control bit 2.
- R8: Control bit 1 (transmit) and control bit 0 (receive), while set, hold their queue empty and drop its pushes. The other queue is unaffected.
- R9: Writing control with bit 16 set empties both queues and clears both flags at that edge. The write leaves the levels and the control bits 3:0 unchanged, and bit 16 always reads as 0.
- R10: `txData` shows the oldest transmit entry and `txValid` is high while that queue is not empty. A `txPop` on an empty queue is ignored, and `txData` is zero when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe; pops the receive queue at address 3 |
| hostAddr | input | 3 | Host word address |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, combinational from address |
| txPop | input | 1 | Shifter takes one transmit sample |
| txData | output | 16 | Oldest transmit sample |
| txValid | output | 1 | Transmit queue not empty |
| rxPush | input | 1 | Shifter delivers one receive sample |
| rxData | input | 16 | Receive sample from the shifter |
| txReq | output | 1 | Transmit-low request |
| rxReq | output | 1 | Receive-high request |

## Verification
The assertions check the following properties on every cycle:
- no queue count exceeds its depth;
- a push into a full queue leaves the count still;
- a queue clear leaves the count at zero;
- a flag set condition is always followed by the flag;
- a flag survives any cycle without a clearing write;
- a soft reset drops both flags.

The bench scenarios show what no single-cycle property can: that data leave in write order, the exact value of each threshold comparison, and the independence of the two queue resets. To do this, the bench sweeps every level value against every fill level from 1 to 33 in both directions. It also checks that zero is returned from empty reads and that the enables and levels survive a soft reset.

// File: rtl/afr_pkg.sv
package afr_pkg;
  localparam int REG_W = 32;

  // host word addresses
  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_STAT = 3'd1;
  localparam logic [2:0] ADDR_TXD  = 3'd2;
  localparam logic [2:0] ADDR_RXD  = 3'd3;
  localparam logic [2:0] ADDR_LVL  = 3'd4;

  // status word positions
  localparam int TXCNT_LSB = 24;
  localparam int RXCNT_LSB = 8;
  localparam int TXFLG_BIT = 16;
  localparam int RXFLG_BIT = 0;

  // level register positions
  localparam int TXLVL_LSB = 8;
  localparam int RXLVL_LSB = 0;

  // control positions
  localparam int RXRST_BIT = 0;
  localparam int TXRST_BIT = 1;
  localparam int RXEN_BIT  = 2;
  localparam int TXEN_BIT  = 3;
  localparam int SRST_BIT  = 16;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txClr;
    logic rxClr;
  } fifoStrobe_t;
endpackage

// File: rtl/afr_fifo.sv
module afr_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] headData,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic full, empty, pushOk, popOk;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign pushOk = push && !full && !clr;
  assign popOk  = pop && !empty && !clr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      case ({pushOk, popOk})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign headData = empty ? '0 : mem[rdPtr];

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R3
  full_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !clr) |=> $stable(count));

  // R8
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (count == '0));

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop && !push) |=> (count == '0));
endmodule

// File: rtl/afr_datapath.sv
module afr_datapath
  import afr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] hostData,
  input  logic              txPop,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxSerData,
  output logic [DATA_W-1:0] txHead,
  output logic [DATA_W-1:0] rxHead,
  output logic [CNT_W-1:0]  txCnt,
  output logic [CNT_W-1:0]  rxCnt,
  output logic              txValid
);
  // index 0 = transmit, 1 = receive
  logic [1:0] pushV, popV, clrV;
  logic [DATA_W-1:0] inV   [2];
  logic [DATA_W-1:0] headV [2];
  logic [CNT_W-1:0]  cntV  [2];

  assign pushV = {rxPush, strobe.txPush};
  assign popV  = {strobe.rxPop, txPop};
  assign clrV  = {strobe.rxClr, strobe.txClr};
  assign inV[0] = hostData;
  assign inV[1] = rxSerData;

  for (genvar d = 0; d < 2; d++) begin : gDir
    afr_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uFifo (
      .clk      (clk),
      .rstN     (rstN),
      .clr      (clrV[d]),
      .push     (pushV[d]),
      .pop      (popV[d]),
      .pushData (inV[d]),
      .headData (headV[d]),
      .count    (cntV[d])
    );
  end

  assign txHead  = headV[0];
  assign rxHead  = headV[1];
  assign txCnt   = cntV[0];
  assign rxCnt   = cntV[1];
  assign txValid = (cntV[0] != '0);
endmodule

// File: rtl/afr_ctrl.sv
module afr_ctrl
  import afr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int LVL_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [2:0]        hostAddr,
  input  logic [REG_W-1:0]  hostWdata,
  output logic [REG_W-1:0]  hostRdata,
  input  logic [CNT_W-1:0]  txCnt,
  input  logic [CNT_W-1:0]  rxCnt,
  input  logic [DATA_W-1:0] rxHead,
  output fifoStrobe_t       strobe,
  output logic              txReq,
  output logic              rxReq
);
  logic txRstQ, rxRstQ, txEnQ, rxEnQ;
  logic [LVL_W-1:0] txLvlQ, rxLvlQ;
  logic txFlagQ, rxFlagQ;
  logic ctrlWr, statWr, lvlWr, softPulse;
  logic txLow, rxHigh, txClrWr, rxClrWr;
  logic unusedWdata;

  assign ctrlWr    = hostWr && (hostAddr == ADDR_CTRL);
  assign statWr    = hostWr && (hostAddr == ADDR_STAT);
  assign lvlWr     = hostWr && (hostAddr == ADDR_LVL);
  assign softPulse = ctrlWr && hostWdata[SRST_BIT];
  assign txClrWr   = statWr && !hostWdata[TXFLG_BIT];
  assign rxClrWr   = statWr && !hostWdata[RXFLG_BIT];
  assign unusedWdata = ^hostWdata[REG_W-1:SRST_BIT+1];

  assign txLow  = (txCnt <= CNT_W'(txLvlQ));
  assign rxHigh = (rxCnt >  CNT_W'(rxLvlQ));

  assign strobe.txPush = hostWr && (hostAddr == ADDR_TXD);
  assign strobe.rxPop  = hostRd && (hostAddr == ADDR_RXD);
  assign strobe.txClr  = txRstQ || softPulse;
  assign strobe.rxClr  = rxRstQ || softPulse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txRstQ <= 1'b0;
      rxRstQ <= 1'b0;
      txEnQ  <= 1'b0;
      rxEnQ  <= 1'b0;
      txLvlQ <= '0;
      rxLvlQ <= '0;
    end else begin
      if (ctrlWr && !softPulse) begin
        rxRstQ <= hostWdata[RXRST_BIT];
        txRstQ <= hostWdata[TXRST_BIT];
        rxEnQ  <= hostWdata[RXEN_BIT];
        txEnQ  <= hostWdata[TXEN_BIT];
      end
      if (lvlWr) begin
        txLvlQ <= hostWdata[TXLVL_LSB +: LVL_W];
        rxLvlQ <= hostWdata[RXLVL_LSB +: LVL_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFlagQ <= 1'b0;
      rxFlagQ <= 1'b0;
    end else if (softPulse) begin
      txFlagQ <= 1'b0;
      rxFlagQ <= 1'b0;
    end else begin
      txFlagQ <= txLow  || (txFlagQ && !txClrWr);
      rxFlagQ <= rxHigh || (rxFlagQ && !rxClrWr);
    end
  end

  assign txReq = txFlagQ && txEnQ;
  assign rxReq = rxFlagQ && rxEnQ;

  always_comb begin
    hostRdata = '0;
    case (hostAddr)
      ADDR_CTRL: begin
        hostRdata[RXRST_BIT] = rxRstQ;
        hostRdata[TXRST_BIT] = txRstQ;
        hostRdata[RXEN_BIT]  = rxEnQ;
        hostRdata[TXEN_BIT]  = txEnQ;
      end
      ADDR_STAT: begin
        hostRdata[TXCNT_LSB +: CNT_W] = txCnt;
        hostRdata[RXCNT_LSB +: CNT_W] = rxCnt;
        hostRdata[TXFLG_BIT]          = txFlagQ;
        hostRdata[RXFLG_BIT]          = rxFlagQ;
      end
      ADDR_RXD: hostRdata[DATA_W-1:0] = rxHead;
      ADDR_LVL: begin
        hostRdata[TXLVL_LSB +: LVL_W] = txLvlQ;
        hostRdata[RXLVL_LSB +: LVL_W] = rxLvlQ;
      end
      default: hostRdata = '0;
    endcase
  end

  // R4
  tx_flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!softPulse && txCnt <= CNT_W'(txLvlQ)) |=> txFlagQ);

  // R5
  rx_flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!softPulse && rxCnt > CNT_W'(rxLvlQ)) |=> rxFlagQ);

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txFlagQ && !statWr && !softPulse) |=> txFlagQ);

  // R9
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    softPulse |=> (!txFlagQ && !rxFlagQ && txCnt == '0 && rxCnt == '0));
endmodule

// File: rtl/audio_fifo_req.sv
module audio_fifo_req
  import afr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [2:0]        hostAddr,
  input  logic [REG_W-1:0]  hostWdata,
  output logic [REG_W-1:0]  hostRdata,
  input  logic              txPop,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxData,
  output logic              txReq,
  output logic              rxReq
);
  fifoStrobe_t strobe;
  logic [CNT_W-1:0]  txCnt, rxCnt;
  logic [DATA_W-1:0] rxHead;

  afr_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .txCnt     (txCnt),
    .rxCnt     (rxCnt),
    .rxHead    (rxHead),
    .strobe    (strobe),
    .txReq     (txReq),
    .rxReq     (rxReq)
  );

  afr_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostData  (hostWdata[DATA_W-1:0]),
    .txPop     (txPop),
    .rxPush    (rxPush),
    .rxSerData (rxData),
    .txHead    (txData),
    .rxHead    (rxHead),
    .txCnt     (txCnt),
    .rxCnt     (rxCnt),
    .txValid   (txValid)
  );
endmodule

// File: tb/sim_audio_fifo_req.sv
`timescale 1ns/1ps
module sim_audio_fifo_req;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_TXD = 3'd2,
                         A_RXD = 3'd3, A_LVL = 3'd4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWr = 1'b0, hostRd = 1'b0;
  logic [2:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic txPop = 1'b0, rxPush = 1'b0;
  logic [15:0] txData, rxData = '0;
  logic txValid, txReq, rxReq;

  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  audio_fifo_req u0 (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .txPop(txPop), .txData(txData), .txValid(txValid),
    .rxPush(rxPush), .rxData(rxData), .txReq(txReq), .rxReq(rxReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    hostAddr = a;
    #1 d = hostRdata;
  endtask

  task automatic popRx(output logic [31:0] d);
    @(negedge clk);
    hostAddr = A_RXD; hostRd = 1'b1;
    #1 d = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic pushRx(input logic [15:0] d);
    @(negedge clk);
    rxPush = 1'b1; rxData = d;
    @(negedge clk);
    rxPush = 1'b0;
  endtask

  task automatic popTx(output logic [15:0] d, output logic v);
    @(negedge clk);
    #1 d = txData; v = txValid;
    txPop = 1'b1;
    @(negedge clk);
    txPop = 1'b0;
  endtask

  function automatic logic [15:0] txVal(input int t, input int n);
    return 16'((t * 37 + n * 1021) & 16'hFFFF);
  endfunction

  function automatic logic [15:0] rxVal(input int t, input int n);
    return 16'((t * 53 + n * 419 + 7) & 16'hFFFF);
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    #(150000 * 5);
    nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [15:0] d;
    logic v;
    int expCnt;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state (R2, R4)
    peek(A_STAT, r);
    chk("R2 reset status", r, 32'h0);
    @(negedge clk);
    peek(A_STAT, r);
    chk("R4 empty tx flags at level 0", r, 32'h0001_0000);
    chk("R10 reset txValid", {31'b0, txValid}, 32'h0);
    chk("R10 reset txData", {16'b0, txData}, 32'h0);
    peek(A_CTRL, r);
    chk("R9 reset ctrl", r, 32'h0);
    peek(A_RXD, r);
    chk("R3 empty rx read", r, 32'h0);

    // transmit sweep: every level against every fill level
    wr(A_CTRL, 32'h8);
    for (int t = 0; t < 32; t++) begin
      wr(A_LVL, 32'(t) << 8);
      wr(A_CTRL, 32'h1_0000);
      peek(A_STAT, r);
      chk("R9 tx count after soft reset", {26'b0, r[29:24]}, 32'h0);
      for (int n = 1; n <= 33; n++) begin
        wr(A_TXD, {16'h0, txVal(t, n)});
        expCnt = (n > 32) ? 32 : n;
        peek(A_STAT, r);
        chk(n > 32 ? "R3 tx write when full" : "R2 tx count", {26'b0, r[29:24]}, 32'(expCnt));
        wr(A_STAT, 32'h0);
        @(negedge clk);
        peek(A_STAT, r);
        chk("R4 tx flag vs level", {31'b0, r[16]}, {31'b0, expCnt <= t});
        chk("R7 txReq enabled", {31'b0, txReq}, {31'b0, expCnt <= t});
      end
      for (int k = 1; k <= 33; k++) begin
        popTx(d, v);
        if (k <= 32) begin
          chk("R1 tx order", {16'b0, d}, {16'b0, txVal(t, k)});
          chk("R10 txValid", {31'b0, v}, 32'h1);
        end else begin
          chk("R10 tx empty data", {16'b0, d}, 32'h0);
          chk("R10 tx empty valid", {31'b0, v}, 32'h0);
        end
      end
      peek(A_STAT, r);
      chk("R10 pop on empty keeps 0", {26'b0, r[29:24]}, 32'h0);
    end

    // receive sweep
    wr(A_CTRL, 32'hC);
    for (int t = 0; t < 32; t++) begin
      wr(A_LVL, 32'(t));
      wr(A_CTRL, 32'h1_0000);
      for (int n = 1; n <= 33; n++) begin
        pushRx(rxVal(t, n));
        expCnt = (n > 32) ? 32 : n;
        peek(A_STAT, r);
        chk(n > 32 ? "R3 rx push when full" : "R2 rx count", {26'b0, r[13:8]}, 32'(expCnt));
        wr(A_STAT, 32'h0);
        @(negedge clk);
        peek(A_STAT, r);
        chk("R5 rx flag vs level", {31'b0, r[0]}, {31'b0, expCnt > t});
        chk("R7 rxReq enabled", {31'b0, rxReq}, {31'b0, expCnt > t});
      end
      for (int k = 1; k <= 33; k++) begin
        popRx(r);
        chk(k <= 32 ? "R1 rx order" : "R3 rx empty read",
            r, k <= 32 ? {16'b0, rxVal(t, k)} : 32'h0);
      end
      peek(A_STAT, r);
      chk("R3 rx count after empty read", {26'b0, r[13:8]}, 32'h0);
    end

    // R6: sticky flag, write 1 keeps it, write 0 clears
    wr(A_LVL, 32'h0);
    pushRx(16'h1234);
    popRx(r);
    @(negedge clk);
    peek(A_STAT, r);
    chk("R6 rx flag sticky after drain", {31'b0, r[0]}, 32'h1);
    wr(A_STAT, 32'h0001_0001);
    peek(A_STAT, r);
    chk("R6 write 1 keeps rx flag", {31'b0, r[0]}, 32'h1);
    wr(A_STAT, 32'h0001_0000);
    peek(A_STAT, r);
    chk("R6 write 0 clears rx flag", {31'b0, r[0]}, 32'h0);

    // R7: enables gate requests
    wr(A_CTRL, 32'h0);
    pushRx(16'h5555);
    @(negedge clk);
    peek(A_STAT, r);
    chk("R7 rx flag set", {31'b0, r[0]}, 32'h1);
    chk("R7 rxReq off when disabled", {31'b0, rxReq}, 32'h0);
    chk("R7 txReq off when disabled", {31'b0, txReq}, 32'h0);
    wr(A_CTRL, 32'h4);
    chk("R7 rxReq on when enabled", {31'b0, rxReq}, 32'h1);

    // R8: independent queue resets (rx holds 1 sample)
    wr(A_CTRL, 32'h6);
    wr(A_TXD, 32'h1111);
    wr(A_TXD, 32'h2222);
    peek(A_STAT, r);
    chk("R8 tx held empty", {26'b0, r[29:24]}, 32'h0);
    chk("R8 rx untouched by tx reset", {26'b0, r[13:8]}, 32'h1);
    pushRx(16'h6666);
    peek(A_STAT, r);
    chk("R8 rx pushes during tx reset", {26'b0, r[13:8]}, 32'h2);
    wr(A_CTRL, 32'h4);
    wr(A_TXD, 32'h3333);
    peek(A_STAT, r);
    chk("R8 tx works after release", {26'b0, r[29:24]}, 32'h1);
    chk("R8 tx head after release", {16'b0, txData}, 32'h3333);
    wr(A_CTRL, 32'h5);
    @(negedge clk);
    peek(A_STAT, r);
    chk("R8 rx held empty", {26'b0, r[13:8]}, 32'h0);
    chk("R8 tx untouched by rx reset", {26'b0, r[29:24]}, 32'h1);
    pushRx(16'h7777);
    peek(A_STAT, r);
    chk("R8 rx push dropped in reset", {26'b0, r[13:8]}, 32'h0);

    // R9: soft reset keeps configuration
    wr(A_CTRL, 32'hC);
    wr(A_LVL, 32'h0000_0305);
    pushRx(16'h0A0A);
    pushRx(16'h0B0B);
    wr(A_TXD, 32'h0C0C);
    wr(A_CTRL, 32'h1_0000);
    peek(A_STAT, r);
    chk("R9 soft reset clears status", r, 32'h0);
    peek(A_LVL, r);
    chk("R9 levels kept", r, 32'h0000_0305);
    peek(A_CTRL, r);
    chk("R9 ctrl kept, bit 16 reads 0", r, 32'h0000_000C);
    @(negedge clk);
    peek(A_STAT, r);
    chk("R9 tx flag returns after soft reset", r, 32'h0001_0000);

    summary();
    $finish;
  end
endmodule